// File: doc/BRIEF.md
# USB Device Interrupt Aggregator

This block gathers the device-side event sources of a USB device controller into a single global status word and one level interrupt line. Two summary bits, one for IN endpoints and one for OUT endpoints, are live ORs of per-endpoint pending registers kept inside the block. Each endpoint's pending bit is set and cleared by per-endpoint strobes from the endpoint logic. The summary bits therefore follow those pending bits and cannot be written from the register port.

Six further flags latch one-cycle events and stay set until software clears them by writing 1. These are: end of the periodic part of a frame, an isochronous OUT packet dropped for lack of receive space, enumeration complete, bus reset seen, early suspend and suspend. The end-of-periodic-frame event comes from a frame-elapsed counter. It compares the counter with a selectable percentage of the frame length. Both suspend events come from a bus-idle timer sized for 3 ms at the configured clock. That timer also drives a suspended-state output.

A mask register with the same layout as the status word gates the interrupt line. All registers sit behind a simple word-wide write strobe with an address. The read data port is combinational.

Top module: `usb_dev_irq_agg`

## Requirements
- R1: Status (address 0) places OUT summary at bit 19, IN summary at bit 18, periodic-frame end at 15, isochronous drop at 14, enumeration done at 13, bus reset at 12, suspend at 11 and early suspend at 10. Every other bit reads 0. Address 1 reads the mask. Address 2 reads the endpoint pending bits, IN endpoint i at bit i and OUT endpoint i at bit 16+i.
- R2: Bit 19 reads 1 exactly while any OUT endpoint pending bit is set. A pending bit is set by its set strobe and cleared only by its clear strobe, and a set wins over a simultaneous clear. Register writes to bit 19 have no effect.
- R3: Bit 18 behaves as R2 does, using the IN endpoint strobes.
- R4: An isochronous OUT packet strobe sets bit 14 on the next edge when the free receive space is smaller than the maximum packet size. With free space equal to or larger than that size, it does not set the bit.
- R5: Setting pfi_sel_i to 0, 1, 2 or 3 gives a threshold T of 80, 85, 90 or 95 percent of the frame length in clock cycles (rounded down). Bit 15 becomes 1 on the T+1-th edge after the edge that captures sof_i, and not earlier.
- R6: An enumeration-done strobe sets bit 13 and a bus-reset strobe sets bit 12, each on the next edge.
- R7: After 3 ms worth of consecutive clock edges with bus_active_i low, bits 11 and 10 are set together and suspended_o goes high on that edge. suspended_o falls on the first edge at which bus_active_i is high.
- R8: The suspend flags fire once per idle period. Once cleared while the bus stays idle they remain clear. Activity before expiry restarts the full idle count.
- R9: Writing 1 to any of bits 15:10 at address 0 clears that flag, and writing 0 leaves it unchanged. When an event and a clear of the same flag fall in the same cycle, the flag stays set.
- R10: Only the mask bits 19:18 and 15:10 can be written, and the others read 0. irq_o is high exactly when some status bit and the same mask bit are both 1.
- R11: After reset, all three registers read 0, and irq_o and suspended_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 status, 1 mask, 2 endpoint pending) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| ep_in_set_i | input | N_EP | Per-IN-endpoint interrupt set strobes |
| ep_in_clr_i | input | N_EP | Per-IN-endpoint interrupt clear strobes |
| ep_out_set_i | input | N_EP | Per-OUT-endpoint interrupt set strobes |
| ep_out_clr_i | input | N_EP | Per-OUT-endpoint interrupt clear strobes |
| sof_i | input | 1 | Start-of-frame strobe |
| pfi_sel_i | input | 2 | Periodic frame interval select |
| iso_pkt_i | input | 1 | Isochronous OUT packet arrival strobe |
| rx_free_i | input | FIFO_W | Free receive FIFO space |
| iso_mps_i | input | FIFO_W | Maximum packet size of the isochronous endpoint |
| enum_done_i | input | 1 | Speed enumeration complete strobe |
| bus_reset_i | input | 1 | Bus reset detected strobe |
| bus_active_i | input | 1 | High while the data lines show activity |
| suspended_o | output | 1 | Suspended state |
| irq_o | output | 1 | Masked interrupt |

## Verification
The assertions check on every cycle that each event strobe turns into its status bit one edge later: endpoint set strobes into the summary bits, isochronous drops, enumeration and bus reset. They also check that the suspended state is entered only after idle, is held while idle and is left on activity, and that a zero mask keeps the interrupt low. Behaviours that depend on counting and on history are shown only by the bench's scenarios. These are the exact edge of the periodic-frame threshold for each select value, the length of the idle window, the single firing per idle period and the restart after brief activity. The scenarios also cover the set-over-clear precedence of the write-one-to-clear path and the read-only nature of the summary bits.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    // Status word bit positions (software decodes these)
    localparam int B_OUT_EP   = 19;
    localparam int B_IN_EP    = 18;
    localparam int B_FRM_END  = 15;
    localparam int B_ISO_DROP = 14;
    localparam int B_ENUM     = 13;
    localparam int B_BUSRST   = 12;
    localparam int B_SUSP     = 11;
    localparam int B_ESUSP    = 10;

    // Latched flags occupy a contiguous field starting at FLAG_LO
    localparam int FLAG_LO = B_ESUSP;
    localparam int N_FLAGS = B_FRM_END - B_ESUSP + 1;

    localparam int F_ESUSP    = B_ESUSP    - FLAG_LO;
    localparam int F_SUSP     = B_SUSP     - FLAG_LO;
    localparam int F_BUSRST   = B_BUSRST   - FLAG_LO;
    localparam int F_ENUM     = B_ENUM     - FLAG_LO;
    localparam int F_ISO_DROP = B_ISO_DROP - FLAG_LO;
    localparam int F_FRM_END  = B_FRM_END  - FLAG_LO;

    // Bits that carry state in status and mask
    localparam logic [31:0] LIVE_BITS = 32'h000C_FC00;

    // Offset of the OUT half of the endpoint pending word
    localparam int EP_OUT_OFS = 16;

    typedef enum logic [1:0] {
        A_STATUS = 2'd0,
        A_MASK   = 2'd1,
        A_EPPEND = 2'd2,
        A_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [N_FLAGS-1:0] flags;
        logic [31:0]        mask;
    } agg_state_t;

endpackage

// File: rtl/usb_ep_pend.sv
module usb_ep_pend #(
    parameter int N_EP = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_EP-1:0] set_i,
    input  logic [N_EP-1:0] clr_i,
    output logic [N_EP-1:0] pend_o,
    output logic            any_o
);

    logic [N_EP-1:0] pend_d, pend_q;

    always_comb begin
        // set has priority over a clear in the same cycle
        pend_d = (pend_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= '0;
        else         pend_q <= pend_d;
    end

    assign pend_o = pend_q;
    assign any_o  = |pend_q;

endmodule

// File: rtl/usb_frame_end_det.sv
module usb_frame_end_det #(
    parameter int FRAME_CYCLES = 7500
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       sof_i,
    input  logic [1:0] sel_i,
    output logic       hit_o
);

    localparam int CNT_W = $clog2(FRAME_CYCLES + 1);
    localparam int THR0  = (FRAME_CYCLES * 80) / 100;
    localparam int THR1  = (FRAME_CYCLES * 85) / 100;
    localparam int THR2  = (FRAME_CYCLES * 90) / 100;
    localparam int THR3  = (FRAME_CYCLES * 95) / 100;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] thr;

    always_comb begin
        unique case (sel_i)
            2'd0:    thr = CNT_W'(THR0);
            2'd1:    thr = CNT_W'(THR1);
            2'd2:    thr = CNT_W'(THR2);
            default: thr = CNT_W'(THR3);
        endcase

        // elapsed count restarts at each frame start and parks at the frame length
        if (sof_i)                               cnt_d = '0;
        else if (cnt_q < CNT_W'(FRAME_CYCLES))   cnt_d = cnt_q + 1'b1;
        else                                     cnt_d = cnt_q;

        hit_o = (cnt_q == thr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= CNT_W'(FRAME_CYCLES);
        else         cnt_q <= cnt_d;
    end

endmodule

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
    parameter int IDLE_CYCLES = 180000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    output logic expire_o,
    output logic suspended_o
);

    localparam int CNT_W = $clog2(IDLE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
        logic             susp;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (active_i) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
            st_d.susp  = 1'b0;
        end else if (!st_q.fired) begin
            if (st_q.cnt == CNT_W'(IDLE_CYCLES - 1)) begin
                expire_o   = 1'b1;
                st_d.fired = 1'b1;
                st_d.susp  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign suspended_o = st_q.susp;

endmodule

// File: rtl/usb_dev_irq_agg.sv
module usb_dev_irq_agg
    import usb_irq_pkg::*;
#(
    parameter int N_EP     = 4,      // at most 16
    parameter int FIFO_W   = 12,
    parameter int CLK_KHZ  = 60000,
    parameter int FRAME_US = 125
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic [N_EP-1:0]   ep_in_set_i,
    input  logic [N_EP-1:0]   ep_in_clr_i,
    input  logic [N_EP-1:0]   ep_out_set_i,
    input  logic [N_EP-1:0]   ep_out_clr_i,
    input  logic              sof_i,
    input  logic [1:0]        pfi_sel_i,
    input  logic              iso_pkt_i,
    input  logic [FIFO_W-1:0] rx_free_i,
    input  logic [FIFO_W-1:0] iso_mps_i,
    input  logic              enum_done_i,
    input  logic              bus_reset_i,
    input  logic              bus_active_i,
    output logic              suspended_o,
    output logic              irq_o
);

    localparam int IDLE_CYCLES  = CLK_KHZ * 3;
    localparam int FRAME_CYCLES = (CLK_KHZ * FRAME_US) / 1000;

    // index 0 = IN direction, index 1 = OUT direction
    logic [1:0][N_EP-1:0] dir_set, dir_clr, dir_pend;
    logic [1:0]           dir_any;

    assign dir_set[0] = ep_in_set_i;
    assign dir_clr[0] = ep_in_clr_i;
    assign dir_set[1] = ep_out_set_i;
    assign dir_clr[1] = ep_out_clr_i;

    for (genvar g = 0; g < 2; g++) begin : g_dir
        usb_ep_pend #(.N_EP(N_EP)) u_pend (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (dir_set[g]),
            .clr_i  (dir_clr[g]),
            .pend_o (dir_pend[g]),
            .any_o  (dir_any[g])
        );
    end

    logic frm_hit;
    usb_frame_end_det #(.FRAME_CYCLES(FRAME_CYCLES)) u_frm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sof_i  (sof_i),
        .sel_i  (pfi_sel_i),
        .hit_o  (frm_hit)
    );

    logic idle_expire;
    usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .active_i    (bus_active_i),
        .expire_o    (idle_expire),
        .suspended_o (suspended_o)
    );

    agg_state_t         st_d, st_q;
    logic [N_FLAGS-1:0] flag_set, flag_clr;
    logic [31:0]        sts_w, mask_w, ep_word;

    always_comb begin
        flag_set             = '0;
        flag_set[F_ESUSP]    = idle_expire;
        flag_set[F_SUSP]     = idle_expire;
        flag_set[F_BUSRST]   = bus_reset_i;
        flag_set[F_ENUM]     = enum_done_i;
        flag_set[F_ISO_DROP] = iso_pkt_i && (rx_free_i < iso_mps_i);
        flag_set[F_FRM_END]  = frm_hit;

        flag_clr = '0;
        if (reg_wr_i && reg_addr_i == A_STATUS)
            flag_clr = reg_wdata_i[FLAG_LO +: N_FLAGS];

        st_d       = st_q;
        st_d.flags = (st_q.flags & ~flag_clr) | flag_set;
        if (reg_wr_i && reg_addr_i == A_MASK)
            st_d.mask = reg_wdata_i & LIVE_BITS;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        sts_w                      = '0;
        sts_w[B_OUT_EP]            = dir_any[1];
        sts_w[B_IN_EP]             = dir_any[0];
        sts_w[FLAG_LO +: N_FLAGS]  = st_q.flags;

        ep_word = '0;
        for (int i = 0; i < N_EP; i++) begin
            ep_word[i]              = dir_pend[0][i];
            ep_word[EP_OUT_OFS + i] = dir_pend[1][i];
        end

        unique case (reg_addr_e'(reg_addr_i))
            A_STATUS: reg_rdata_o = sts_w;
            A_MASK:   reg_rdata_o = st_q.mask;
            A_EPPEND: reg_rdata_o = ep_word;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign mask_w = st_q.mask;
    assign irq_o  = |(sts_w & st_q.mask);

endmodule

// File: rtl/usb_dev_irq_agg_chk.sv
module usb_dev_irq_agg_chk #(
    parameter int N_EP   = 4,
    parameter int FIFO_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [N_EP-1:0]   ep_in_set_i,
    input logic [N_EP-1:0]   ep_out_set_i,
    input logic              iso_pkt_i,
    input logic [FIFO_W-1:0] rx_free_i,
    input logic [FIFO_W-1:0] iso_mps_i,
    input logic              enum_done_i,
    input logic              bus_reset_i,
    input logic              bus_active_i,
    input logic              suspended_o,
    input logic              irq_o,
    input logic [31:0]       sts_w,
    input logic [31:0]       mask_w
);

    assert_out_sum_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ep_out_set_i) |=> sts_w[19]);

    assert_in_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ep_in_set_i) |=> sts_w[18]);

    assert_iso_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (iso_pkt_i && (rx_free_i < iso_mps_i)) |=> sts_w[14]);

    assert_enum_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enum_done_i |=> sts_w[13]);

    assert_busrst_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_reset_i |=> sts_w[12]);

    assert_susp_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_active_i |=> !suspended_o);

    assert_susp_pair_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sts_w[11]) && $rose(suspended_o) |-> sts_w[10]);

    assert_susp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (suspended_o && !bus_active_i) |=> suspended_o);

    assert_susp_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(suspended_o) |-> $past(!bus_active_i));

    assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_w == 32'h0) |-> !irq_o);

    assert_irq_raise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_w[13] && mask_w[13]) |-> irq_o);

endmodule

bind usb_dev_irq_agg usb_dev_irq_agg_chk #(.N_EP(N_EP), .FIFO_W(FIFO_W)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ep_in_set_i  (ep_in_set_i),
    .ep_out_set_i (ep_out_set_i),
    .iso_pkt_i    (iso_pkt_i),
    .rx_free_i    (rx_free_i),
    .iso_mps_i    (iso_mps_i),
    .enum_done_i  (enum_done_i),
    .bus_reset_i  (bus_reset_i),
    .bus_active_i (bus_active_i),
    .suspended_o  (suspended_o),
    .irq_o        (irq_o),
    .sts_w        (sts_w),
    .mask_w       (mask_w)
);

// File: tb/usb_dev_irq_agg_tb.sv
module usb_dev_irq_agg_tb;

    localparam int N_EP     = 4;
    localparam int FIFO_W   = 12;
    localparam int CLK_KHZ  = 100;
    localparam int FRAME_US = 1000;
    localparam int IDLE     = CLK_KHZ * 3;              // 300 edges
    localparam int FRAME    = (CLK_KHZ * FRAME_US) / 1000; // 100 cycles

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [N_EP-1:0]   in_set = '0, in_clr = '0, out_set = '0, out_clr = '0;
    logic              sof = 1'b0;
    logic [1:0]        pfi_sel = 2'd0;
    logic              iso_pkt = 1'b0;
    logic [FIFO_W-1:0] rx_free = '0, iso_mps = '0;
    logic              enum_done = 1'b0, bus_reset = 1'b0, bus_active = 1'b1;
    logic              suspended, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    usb_dev_irq_agg #(
        .N_EP(N_EP), .FIFO_W(FIFO_W), .CLK_KHZ(CLK_KHZ), .FRAME_US(FRAME_US)
    ) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .ep_in_set_i(in_set), .ep_in_clr_i(in_clr),
        .ep_out_set_i(out_set), .ep_out_clr_i(out_clr),
        .sof_i(sof), .pfi_sel_i(pfi_sel),
        .iso_pkt_i(iso_pkt), .rx_free_i(rx_free), .iso_mps_i(iso_mps),
        .enum_done_i(enum_done), .bus_reset_i(bus_reset),
        .bus_active_i(bus_active),
        .suspended_o(suspended), .irq_o(irq)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 2'd0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); chk("R11 status after reset", d, 32'h0);
        rd(2'd1, d); chk("R11 mask after reset", d, 32'h0);
        rd(2'd2, d); chk("R11 ep pending after reset", d, 32'h0);
        chk("R11 irq after reset", {31'b0, irq}, 32'h0);
        chk("R11 suspended after reset", {31'b0, suspended}, 32'h0);
    endtask

    task automatic t_endpoints();
        logic [31:0] d;
        out_set = 4'b0100; step(); out_set = '0;
        rd(2'd0, d); chk("R2 OUT summary set", d, 32'h0008_0000);
        wr(2'd0, 32'h000C_0000);
        rd(2'd0, d); chk("R2 write to summary ignored", d, 32'h0008_0000);
        rd(2'd2, d); chk("R1 ep word OUT ep2 at bit 18", d, 32'h0004_0000);
        in_set = 4'b0001; in_clr = 4'b0001; step(); in_set = '0; in_clr = '0;
        rd(2'd0, d); chk("R3 IN summary set wins over clear", d, 32'h000C_0000);
        rd(2'd2, d); chk("R1 ep word IN ep0 at bit 0", d, 32'h0004_0001);
        out_clr = 4'b0100; step(); out_clr = '0;
        rd(2'd0, d); chk("R2 OUT summary cleared at endpoint", d, 32'h0004_0000);
        in_clr = 4'b0001; step(); in_clr = '0;
        rd(2'd0, d); chk("R3 IN summary cleared at endpoint", d, 32'h0);
    endtask

    task automatic t_iso();
        logic [31:0] d;
        rx_free = 12'd10; iso_mps = 12'd20; iso_pkt = 1'b1; step(); iso_pkt = 1'b0;
        rd(2'd0, d); chk("R4 iso drop when space short", d, 32'h0000_4000);
        wr(2'd0, 32'h0000_4000);
        rd(2'd0, d); chk("R9 iso flag cleared by write 1", d, 32'h0);
        rx_free = 12'd20; iso_pkt = 1'b1; step(); iso_pkt = 1'b0;
        rd(2'd0, d); chk("R4 no drop when space equals size", d, 32'h0);
    endtask

    task automatic t_frame();
        logic [31:0] d;
        for (int s = 0; s < 4; s++) begin
            int thr;
            thr = (FRAME * (80 + 5 * s)) / 100;
            pfi_sel = 2'(s);
            sof = 1'b1; step(); sof = 1'b0;
            repeat (thr) step();
            rd(2'd0, d); chk($sformatf("R5 no frame-end before threshold sel %0d", s), d, 32'h0);
            step();
            rd(2'd0, d); chk($sformatf("R5 frame-end at threshold sel %0d", s), d, 32'h0000_8000);
            wr(2'd0, 32'h0000_8000);
            repeat (FRAME) step();
            rd(2'd0, d); chk($sformatf("R5 frame-end once per frame sel %0d", s), d, 32'h0);
        end
    endtask

    task automatic t_events();
        logic [31:0] d;
        enum_done = 1'b1; step(); enum_done = 1'b0;
        rd(2'd0, d); chk("R6 enumeration flag", d, 32'h0000_2000);
        bus_reset = 1'b1; step(); bus_reset = 1'b0;
        rd(2'd0, d); chk("R6 bus reset flag", d, 32'h0000_3000);
        wr(2'd0, 32'h0000_1000);
        rd(2'd0, d); chk("R9 write 0 leaves other flag", d, 32'h0000_2000);
        enum_done = 1'b1; wr(2'd0, 32'h0000_2000); enum_done = 1'b0;
        rd(2'd0, d); chk("R9 set wins over clear", d, 32'h0000_2000);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); chk("R10 mask writable bits only", d, 32'h000C_FC00);
        chk("R10 irq with enabled flag", {31'b0, irq}, 32'h1);
        wr(2'd1, 32'h0000_1000);
        chk("R10 irq masked off", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0000_FC00);
        rd(2'd0, d); chk("R9 all flags cleared", d, 32'h0);
    endtask

    task automatic t_idle();
        logic [31:0] d;
        bus_active = 1'b0;
        repeat (IDLE - 1) step();
        rd(2'd0, d); chk("R7 no suspend flags before 3 ms", d, 32'h0);
        chk("R7 not suspended before 3 ms", {31'b0, suspended}, 32'h0);
        step();
        rd(2'd0, d); chk("R7 both suspend flags at 3 ms", d, 32'h0000_0C00);
        chk("R7 suspended at 3 ms", {31'b0, suspended}, 32'h1);
        wr(2'd0, 32'h0000_0C00);
        repeat (IDLE + 20) step();
        rd(2'd0, d); chk("R8 flags stay clear while still idle", d, 32'h0);
        bus_active = 1'b1; step();
        chk("R7 suspended drops on activity", {31'b0, suspended}, 32'h0);
        bus_active = 1'b0;
        repeat (IDLE / 2) step();
        bus_active = 1'b1; step(); bus_active = 1'b0;
        repeat (IDLE - 1) step();
        rd(2'd0, d); chk("R8 activity restarts idle count", d, 32'h0);
        step();
        rd(2'd0, d); chk("R8 new idle period fires again", d, 32'h0000_0C00);
        bus_active = 1'b1; step();
        wr(2'd0, 32'h0000_0C00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_endpoints();
        t_iso();
        t_frame();
        t_events();
        t_mask();
        t_idle();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

endmodule